// File: doc/BRIEF.md
# T-Junction Fixed-Time Signal Sequencer

A synchronous controller for the four signal heads of a T-shaped junction: main road direction A, the main-road turn movement, main road direction B, and the side road. It steps through a fixed cycle of six phases and wraps around indefinitely. Each phase has its own dwell time in whole seconds. The three amber clearance phases share one duration parameter.

A parameterised prescaler turns the clock into a one-cycle seconds tick. The phase timer advances only on that tick, so a phase lasts exactly its dwell time multiplied by the prescaler period, in clock cycles. Each head is driven as a 3-bit field in red/amber/green order. The current phase code is brought out so that the sequence can be observed. Durations are fixed by elaboration parameters. There is no run-time input apart from clock and reset.

Top module: `tjunc_signal_seq`

## Requirements
- R1: Each head output is 3 bits {red, amber, green}: red is 3'b100, amber is 3'b010 and green is 3'b001. Exactly one bit is set in every cycle.
- R2: While rst_ni is low, and without waiting for a clock edge, phase_o is 3'b001 and the heads show the main-green pattern. The seconds prescaler and the dwell timer are cleared.
- R3: phase_o steps through the codes 3'b001, 3'b010, 3'b011, 3'b100, 3'b101 and 3'b110, then returns to 3'b001. No other code ever appears outside reset.
- R4: The phases with codes 001, 011 and 101 last MAIN_GREEN_S, TURN_GREEN_S and SIDE_GREEN_S seconds (defaults 7, 5 and 3). The phases with codes 010, 100 and 110 last AMBER_S seconds (default 2). One second is TICKS_PER_SEC clock cycles, and the first phase after reset lasts its full time.
- R5: In phase 001, direction A and direction B are green while the turn and the side road are red. In phase 010, direction A is green, direction B is amber, and the turn and the side road are red.
- R6: In phase 011, direction A and the turn are green while direction B and the side road are red. In phase 100, direction A and the turn are amber while direction B and the side road are red.
- R7: In phase 101, the three main-road heads are red and the side road is green. In phase 110, the three main-road heads are red and the side road is amber.
- R8: The side road is never green unless all three main-road heads are red.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_o | output | 3 | Current phase code, 001 to 110 |
| main_a_o | output | 3 | Main road direction A head {red, amber, green} |
| turn_o | output | 3 | Main-road turn movement head |
| main_b_o | output | 3 | Main road direction B head |
| side_o | output | 3 | Side road head |

## Verification
Apart from clock and reset, the block has no inputs. The assertions therefore assume only that reset is released away from a clock edge and that TICKS_PER_SEC and the dwell parameters are at least one. The bench releases reset on a falling edge and shrinks the prescaler to four cycles per second. It covers two complete cycles cycle by cycle. Reset is applied once more in the middle of a phase, between clock edges, to show that the asynchronous clear takes effect at once and that timing restarts from the beginning of the main-green phase.

// File: rtl/tjunc_pkg.sv
package tjunc_pkg;

  typedef enum logic [2:0] {
    PH_MAIN       = 3'd1,
    PH_MAIN_AMBER = 3'd2,
    PH_TURN       = 3'd3,
    PH_TURN_AMBER = 3'd4,
    PH_SIDE       = 3'd5,
    PH_SIDE_AMBER = 3'd6
  } phase_e;

  localparam logic [2:0] LAMP_RED   = 3'b100;
  localparam logic [2:0] LAMP_AMBER = 3'b010;
  localparam logic [2:0] LAMP_GREEN = 3'b001;

  typedef struct packed {
    logic [2:0] main_a;
    logic [2:0] turn;
    logic [2:0] main_b;
    logic [2:0] side;
  } heads_t;

endpackage

// File: rtl/tjunc_sec_tick.sv
module tjunc_sec_tick #(
  parameter int unsigned TICKS_PER_SEC = 125_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  generate
    if (TICKS_PER_SEC <= 1) begin : g_pass
      assign tick_o = rst_ni;
    end else begin : g_div
      localparam int unsigned CW = $clog2(TICKS_PER_SEC);
      localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = (cnt_q == LAST);

      p_tick_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
      p_cnt_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST);
    end
  endgenerate

endmodule

// File: rtl/tjunc_phase_fsm.sv
module tjunc_phase_fsm
  import tjunc_pkg::*;
#(
  parameter int unsigned MAIN_GREEN_S = 7,
  parameter int unsigned TURN_GREEN_S = 5,
  parameter int unsigned SIDE_GREEN_S = 3,
  parameter int unsigned AMBER_S      = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  output logic [2:0] phase_o
);

  localparam int unsigned MAX_A = (MAIN_GREEN_S > TURN_GREEN_S) ? MAIN_GREEN_S : TURN_GREEN_S;
  localparam int unsigned MAX_B = (SIDE_GREEN_S > AMBER_S) ? SIDE_GREEN_S : AMBER_S;
  localparam int unsigned MAX_S = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned DW    = (MAX_S > 1) ? $clog2(MAX_S) : 1;

  logic [2:0]    state_q, state_d;
  logic [DW-1:0] dwell_q, dwell_last;
  logic          advance;

  // last tick index of the current phase
  always_comb begin
    unique case (state_q)
      PH_MAIN:                  dwell_last = DW'(MAIN_GREEN_S - 1);
      PH_TURN:                  dwell_last = DW'(TURN_GREEN_S - 1);
      PH_SIDE:                  dwell_last = DW'(SIDE_GREEN_S - 1);
      PH_MAIN_AMBER,
      PH_TURN_AMBER,
      PH_SIDE_AMBER:            dwell_last = DW'(AMBER_S - 1);
      default:                  dwell_last = '0;
    endcase
  end

  assign advance = tick_i && (dwell_q == dwell_last);

  always_comb begin
    case (state_q)
      PH_MAIN:       state_d = PH_MAIN_AMBER;
      PH_MAIN_AMBER: state_d = PH_TURN;
      PH_TURN:       state_d = PH_TURN_AMBER;
      PH_TURN_AMBER: state_d = PH_SIDE;
      PH_SIDE:       state_d = PH_SIDE_AMBER;
      default:       state_d = PH_MAIN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_MAIN;
      dwell_q <= '0;
    end else if (state_q == 3'd0 || state_q == 3'd7) begin
      // corrupted code: restart cycle
      state_q <= PH_MAIN;
      dwell_q <= '0;
    end else if (advance) begin
      state_q <= state_d;
      dwell_q <= '0;
    end else if (tick_i) begin
      dwell_q <= dwell_q + 1'b1;
    end
  end

  assign phase_o = state_q;

  p_legal_code_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q >= 3'd1) && (state_q <= 3'd6));
  p_hold_no_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(state_q));
  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_SIDE_AMBER && advance) |=> state_q == PH_MAIN);
  p_dwell_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dwell_q <= dwell_last);
  p_step_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_MAIN && advance) |=> state_q == PH_MAIN_AMBER);

endmodule

// File: rtl/tjunc_head_decode.sv
module tjunc_head_decode
  import tjunc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] phase_i,
  output heads_t     heads_o
);

  always_comb begin
    heads_o = '{main_a: LAMP_RED, turn: LAMP_RED, main_b: LAMP_RED, side: LAMP_RED};
    case (phase_i)
      PH_MAIN_AMBER: begin
        heads_o.main_a = LAMP_GREEN;
        heads_o.main_b = LAMP_AMBER;
      end
      PH_TURN: begin
        heads_o.main_a = LAMP_GREEN;
        heads_o.turn   = LAMP_GREEN;
      end
      PH_TURN_AMBER: begin
        heads_o.main_a = LAMP_AMBER;
        heads_o.turn   = LAMP_AMBER;
      end
      PH_SIDE:       heads_o.side = LAMP_GREEN;
      PH_SIDE_AMBER: heads_o.side = LAMP_AMBER;
      default: begin
        heads_o.main_a = LAMP_GREEN;
        heads_o.main_b = LAMP_GREEN;
      end
    endcase
  end

  p_one_lamp_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(heads_o.main_a) == 1 && $countones(heads_o.turn) == 1 &&
    $countones(heads_o.main_b) == 1 && $countones(heads_o.side) == 1);
  p_side_safe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    heads_o.side == LAMP_GREEN |->
      (heads_o.main_a == LAMP_RED && heads_o.turn == LAMP_RED && heads_o.main_b == LAMP_RED));
  p_turn_vs_b_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    heads_o.turn != LAMP_RED |-> heads_o.main_b == LAMP_RED);

endmodule

// File: rtl/tjunc_signal_seq.sv
module tjunc_signal_seq
  import tjunc_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 125_000_000,
  parameter int unsigned MAIN_GREEN_S  = 7,
  parameter int unsigned TURN_GREEN_S  = 5,
  parameter int unsigned SIDE_GREEN_S  = 3,
  parameter int unsigned AMBER_S       = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic [2:0] phase_o,
  output logic [2:0] main_a_o,
  output logic [2:0] turn_o,
  output logic [2:0] main_b_o,
  output logic [2:0] side_o
);

  logic   sec_tick;
  logic [2:0] phase;
  heads_t heads;

  tjunc_sec_tick #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (sec_tick)
  );

  tjunc_phase_fsm #(
    .MAIN_GREEN_S (MAIN_GREEN_S),
    .TURN_GREEN_S (TURN_GREEN_S),
    .SIDE_GREEN_S (SIDE_GREEN_S),
    .AMBER_S      (AMBER_S)
  ) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (sec_tick),
    .phase_o (phase)
  );

  tjunc_head_decode u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_i (phase),
    .heads_o (heads)
  );

  assign phase_o  = phase;
  assign main_a_o = heads.main_a;
  assign turn_o   = heads.turn;
  assign main_b_o = heads.main_b;
  assign side_o   = heads.side;

endmodule

// File: tb/tjunc_signal_seq_tb.sv
module tjunc_signal_seq_tb;

  localparam int TPS = 4;
  localparam logic [2:0] R = 3'b100, Y = 3'b010, G = 3'b001;

  // per phase: code, seconds, {main_a, turn, main_b, side}
  localparam logic [2:0]  VCODE [6] = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6};
  localparam int          VSEC  [6] = '{7, 2, 5, 2, 3, 2};
  localparam logic [11:0] VLAMP [6] = '{
    {G, R, G, R}, {G, R, Y, R}, {G, G, R, R},
    {Y, Y, R, R}, {R, R, R, G}, {R, R, R, Y}};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] phase, ma, tu, mb, sd;
  int n_checks = 0, n_errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tjunc_signal_seq #(.TICKS_PER_SEC(TPS)) u_dut (
    .clk_i (clk), .rst_ni (rst_ni), .phase_o (phase),
    .main_a_o (ma), .turn_o (tu), .main_b_o (mb), .side_o (sd)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string lamp_tag(int p);
    if (p < 2) return "R5";
    if (p < 4) return "R6";
    return "R7";
  endfunction

  task automatic check_phase(int p, string why);
    check(phase == VCODE[p], {"R3 phase code ", why}, 32'(phase), 32'(VCODE[p]));
    check({ma, tu, mb, sd} == VLAMP[p], {lamp_tag(p), " lamps ", why}, 32'({ma, tu, mb, sd}), 32'(VLAMP[p]));
  endtask

  task automatic check_static();
    check($countones(ma) == 1 && $countones(tu) == 1 && $countones(mb) == 1 && $countones(sd) == 1,
          "R1 one lamp per head", 32'({ma, tu, mb, sd}), 32'h0);
    check(sd != G || (ma == R && tu == R && mb == R), "R8 side green only with mains red",
          32'({ma, tu, mb, sd}), 32'(VLAMP[4]));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    #(8 * 4000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    // R2: reset state before any release
    #21;
    check_phase(0, "R2 during reset");
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R3/R4/R5/R6/R7: walk two full cycles cycle by cycle
    for (int rep = 0; rep < 2; rep++) begin
      for (int p = 0; p < 6; p++) begin
        for (int c = 0; c < VSEC[p] * TPS; c++) begin
          check_phase(p, "R4 dwell");
          check_static();
          @(negedge clk);
        end
      end
    end
    check_phase(0, "R3 wrap to first");

    // advance into the turn-green phase
    repeat (40) @(negedge clk);
    check_phase(2, "R4 mid cycle");

    // R2: asynchronous reset between edges
    #1 rst_ni = 1'b0;
    #1 check_phase(0, "R2 async clear");
    @(negedge clk);
    rst_ni = 1'b1;

    // R4: full main-green after reset, then the amber phase
    for (int c = 0; c < VSEC[0] * TPS; c++) begin
      check_phase(0, "R4 restart dwell");
      @(negedge clk);
    end
    check_phase(1, "R4 boundary after restart");
    for (int c = 0; c < VSEC[1] * TPS; c++) @(negedge clk);
    check_phase(2, "R4 shared amber length");

    done = 1'b1;
    summary();
  end

endmodule